// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer with Burst Refresh Timer

This block takes an SDRAM from power-up to a usable state and then keeps it refreshed. After reset it holds the command lines at NOP for a long settling time. It then drives a fixed series of commands: precharge-all, a first mode-register load, eight auto-refreshes, a second mode-register load, and ten dummy accesses. Each dummy access is an activate followed by a precharge-all. Only after that series does the block raise its init-done flag.

From then on a prescaled timer requests refresh. Each request produces a burst of four auto-refresh commands. The `rateSlow` input selects a prescaler twice as long, which halves the refresh rate for small devices. Every command is followed by a run of NOP cycles whose length is set by a clock-count parameter for that command. The mode word is placed on the address bus shifted left, because the low address bits do not reach the device on a 32-bit bus.

Top module: `sdr_init_refresh`

## Requirements
- R1: While `rstN` is low, the command pins {sdCsN,sdRasN,sdCasN,sdWeN} read 4'b1111 (inhibit), `sdAddr` is 0 and `initDone` is 0.
- R2: After reset is released, the pins show NOP (4'b0111, address 0) for PWRUP_CYCLES clocks (default 10000, which is 200 us at 50 MHz). The first command, precharge-all, appears in clock PWRUP_CYCLES+1. Precharge-all is encoded 4'b0010 with address bit 10 set.
- R3: The initialization commands follow one fixed order: precharge-all, mode load, eight auto-refreshes (4'b0001, address 0), mode load, then the dummy accesses.
- R4: Both mode loads are encoded 4'b0000, and the address carries MODE_VALUE shifted left by MODE_SHIFT. With the defaults 0x22 and 2, the address is 0x088.
- R5: Every command is followed by a fixed number of NOP clocks before the next command: T_RP after a precharge, T_RFC after a refresh, T_MRD after a mode load and T_RAS after an activate.
- R6: There are ten dummy accesses. Dummy access k (k = 0..9) is an activate (4'b0011) with address k, followed by a precharge-all.
- R7: `initDone` rises T_RP+1 clocks after the last dummy precharge and stays high until reset. No refresh burst is issued before it rises.
- R8: With `rateSlow` low, let D be the clock in which `initDone` first reads high. Refresh bursts start at clock D + n*PRESCALE*REF_PERIOD + 1 for n = 1, 2, and so on (the defaults give one burst every 1560 clocks). Each burst contains REF_BURST (4) auto-refreshes, with T_RFC NOP clocks between them.
- R9: With `rateSlow` high, the burst spacing is 2*PRESCALE*REF_PERIOD clocks (3120 with the defaults). The burst shape and the clock at which bursts start counting are the same as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSlow | input | 1 | High selects the halved refresh rate |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | ADDR_W | Address bus (mode word, row, precharge-all bit) |
| initDone | output | 1 | High once initialization and the dummy accesses are complete |

## Verification
The hardest things to reach from the ports are the refresh bursts at the slow rate and the exact clock at which the refresh timer starts counting. Both lie more than ten thousand clocks past reset, behind the whole initialization series. The bench builds the full expected command schedule from the requirement formulas: power-up wait, every gap, the dummy accesses, the clock at which init-done rises, and the burst start times. It then compares the pins against that schedule on every clock. It makes one pass with the fast rate and a second pass, after a fresh reset, with the slow rate held high. Because the comparison covers every clock, an off-by-one error in any gap, in the prescaler or in the start of the timer shows up as a mismatch.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             doPre;
    logic             doRef;
    logic             doMrs;
    logic             doAct;
    logic [IDX_W-1:0] actRow;
  } sdr_strobe_t;

  typedef enum logic [2:0] {
    ST_PRE, ST_MRS1, ST_IREF, ST_MRS2, ST_DACT, ST_DPRE, ST_IDLE, ST_RBURST
  } sdr_state_t;
endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int PRESCALE   = 8,
  parameter int REF_PERIOD = 195
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic rateSlow,
  output logic tick
);
  localparam int PRE_W = $clog2(2 * PRESCALE + 1);
  localparam int PER_W = $clog2(REF_PERIOD + 1);

  logic [PRE_W-1:0] preCnt;
  logic [PER_W-1:0] perCnt;
  logic [PRE_W-1:0] divLast;
  logic             preWrap;

  assign divLast = rateSlow ? PRE_W'(2 * PRESCALE - 1) : PRE_W'(PRESCALE - 1);
  assign preWrap = (preCnt >= divLast);
  assign tick    = run && preWrap && (perCnt == PER_W'(REF_PERIOD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (!run) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
      perCnt <= (perCnt == PER_W'(REF_PERIOD - 1)) ? '0 : perCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // R8: a request is a single-cycle pulse
  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
endmodule

// File: rtl/sdr_init_ctrl.sv
module sdr_init_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int PWRUP_CYCLES = 10000,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int T_RAS        = 5,
  parameter int INIT_REFS    = 8,
  parameter int DUMMY_ACC    = 10,
  parameter int REF_BURST    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  output sdr_strobe_t ctl,
  output logic        initDone
);
  localparam int MAX_A  = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int MAX_B  = (T_MRD > T_RAS) ? T_MRD : T_RAS;
  localparam int MAX_G  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_W  = (PWRUP_CYCLES > MAX_G) ? PWRUP_CYCLES : MAX_G;
  localparam int WAIT_W = $clog2(MAX_W + 1);

  sdr_state_t        state;
  logic [WAIT_W-1:0] waitCnt;
  logic [IDX_W-1:0]  cnt;
  logic              pending;
  logic              ready;
  logic              accept;

  assign ready  = (waitCnt == '0);
  assign accept = ready && (state == ST_IDLE) && initDone && (tick || pending);

  always_comb begin
    ctl        = '0;
    ctl.doPre  = ready && ((state == ST_PRE) || (state == ST_DPRE));
    ctl.doMrs  = ready && ((state == ST_MRS1) || (state == ST_MRS2));
    ctl.doRef  = ready && ((state == ST_IREF) || (state == ST_RBURST));
    ctl.doAct  = ready && (state == ST_DACT);
    ctl.actRow = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PRE;
      waitCnt  <= WAIT_W'(PWRUP_CYCLES);
      cnt      <= '0;
      initDone <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (accept)    pending <= 1'b0;
      else if (tick) pending <= 1'b1;

      if (!ready) begin
        waitCnt <= waitCnt - 1'b1;
      end else begin
        case (state)
          ST_PRE: begin
            waitCnt <= WAIT_W'(T_RP);
            state   <= ST_MRS1;
          end
          ST_MRS1: begin
            waitCnt <= WAIT_W'(T_MRD);
            cnt     <= '0;
            state   <= ST_IREF;
          end
          ST_IREF: begin
            waitCnt <= WAIT_W'(T_RFC);
            if (cnt == IDX_W'(INIT_REFS - 1)) begin
              cnt   <= '0;
              state <= ST_MRS2;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_MRS2: begin
            waitCnt <= WAIT_W'(T_MRD);
            cnt     <= '0;
            state   <= ST_DACT;
          end
          ST_DACT: begin
            waitCnt <= WAIT_W'(T_RAS);
            state   <= ST_DPRE;
          end
          ST_DPRE: begin
            waitCnt <= WAIT_W'(T_RP);
            if (cnt == IDX_W'(DUMMY_ACC - 1)) begin
              cnt   <= '0;
              state <= ST_IDLE;
            end else begin
              cnt   <= cnt + 1'b1;
              state <= ST_DACT;
            end
          end
          ST_IDLE: begin
            initDone <= 1'b1;
            if (accept) begin
              cnt   <= '0;
              state <= ST_RBURST;
            end
          end
          ST_RBURST: begin
            waitCnt <= WAIT_W'(T_RFC);
            if (cnt == IDX_W'(REF_BURST - 1)) begin
              cnt   <= '0;
              state <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7: once set, the done flag holds until reset
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);
  // R7: refresh bursts only after init completes
  p_burst_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RBURST) |-> initDone);
  // R8: a new request never lands on one still waiting
  p_no_lost_refresh_r8: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> !pending);
endmodule

// File: rtl/sdr_cmd_path.sv
module sdr_cmd_path
  import sdr_seq_pkg::*;
#(
  parameter int          ADDR_W     = 13,
  parameter int          AP_BIT     = 10,
  parameter logic [7:0]  MODE_VALUE = 8'h22,
  parameter int          MODE_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdr_strobe_t       ctl,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr
);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE_VALUE) << MODE_SHIFT;
  localparam logic [ADDR_W-1:0] AP_WORD   = ADDR_W'(1) << AP_BIT;

  logic [3:0] cmdBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits <= 4'b1111;
      sdAddr  <= '0;
    end else if (ctl.doPre) begin
      cmdBits <= 4'b0010;
      sdAddr  <= AP_WORD;
    end else if (ctl.doRef) begin
      cmdBits <= 4'b0001;
      sdAddr  <= '0;
    end else if (ctl.doMrs) begin
      cmdBits <= 4'b0000;
      sdAddr  <= MODE_WORD;
    end else if (ctl.doAct) begin
      cmdBits <= 4'b0011;
      sdAddr  <= ADDR_W'(ctl.actRow);
    end else begin
      cmdBits <= 4'b0111;
      sdAddr  <= '0;
    end
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdBits;

  // R3: at most one command requested per clock
  p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.doPre, ctl.doRef, ctl.doMrs, ctl.doAct}));
  // R5: every command is followed by at least one NOP clock
  p_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doPre || ctl.doRef || ctl.doMrs || ctl.doAct) |=>
      !(ctl.doPre || ctl.doRef || ctl.doMrs || ctl.doAct));
  // R4: a mode load drives the shifted mode word
  p_mode_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doMrs |=> (sdAddr == MODE_WORD) && !sdCsN && !sdRasN && !sdCasN && !sdWeN);
endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int          ADDR_W       = 13,
  parameter int          AP_BIT       = 10,
  parameter logic [7:0]  MODE_VALUE   = 8'h22,
  parameter int          MODE_SHIFT   = 2,
  parameter int          PWRUP_CYCLES = 10000,
  parameter int          T_RP         = 3,
  parameter int          T_RFC        = 7,
  parameter int          T_MRD        = 2,
  parameter int          T_RAS        = 5,
  parameter int          INIT_REFS    = 8,
  parameter int          DUMMY_ACC    = 10,
  parameter int          REF_BURST    = 4,
  parameter int          PRESCALE     = 8,
  parameter int          REF_PERIOD   = 195
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateSlow,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              initDone
);
  sdr_strobe_t ctl;
  logic        tick;

  sdr_init_ctrl #(
    .PWRUP_CYCLES(PWRUP_CYCLES), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .T_RAS(T_RAS), .INIT_REFS(INIT_REFS), .DUMMY_ACC(DUMMY_ACC),
    .REF_BURST(REF_BURST)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctl), .initDone(initDone)
  );

  sdr_refresh_timer #(.PRESCALE(PRESCALE), .REF_PERIOD(REF_PERIOD)) timer_i (
    .clk(clk), .rstN(rstN), .run(initDone), .rateSlow(rateSlow), .tick(tick)
  );

  sdr_cmd_path #(
    .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .MODE_VALUE(MODE_VALUE),
    .MODE_SHIFT(MODE_SHIFT)
  ) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr)
  );
endmodule

// File: tb/sdr_init_refresh_tb.sv
`timescale 1ns/1ps
module sdr_init_refresh_tb_top;
  localparam int PWRUP = 10000;
  localparam int TRP = 3, TRFC = 7, TMRD = 2, TRAS = 5;
  localparam int PRESC = 8, PERIOD = 195;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rateSlow = 1'b0;
  logic sdCsN, sdRasN, sdCasN, sdWeN, initDone;
  logic [AW-1:0] sdAddr;

  int checks = 0;
  int failures = 0;

  int    expCmd[int];
  int    expAddr[int];
  string expReq[int];
  int    doneAt;

  always #10 clk = ~clk;

  sdr_init_refresh #(
    .ADDR_W(AW), .PWRUP_CYCLES(PWRUP), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
    .T_RAS(TRAS), .PRESCALE(PRESC), .REF_PERIOD(PERIOD)
  ) dut_i (
    .clk(clk), .rstN(rstN), .rateSlow(rateSlow), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr), .initDone(initDone)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic put(inout int t, input int cmd, input int addr, input string req, input int gap);
    expCmd[t]  = cmd;
    expAddr[t] = addr;
    expReq[t]  = req;
    t = t + gap + 1;
  endtask

  // Build the expected schedule from the requirements
  task automatic build(input bit slow, input int bursts);
    int t;
    int ival;
    expCmd.delete(); expAddr.delete(); expReq.delete();
    t = PWRUP + 1;
    put(t, 4'b0010, 1 << 10, "R2", TRP);          // R2 precharge-all first
    put(t, 4'b0000, 8'h22 << 2, "R4", TMRD);      // R4 first mode load
    for (int i = 0; i < 8; i++) put(t, 4'b0001, 0, "R3", TRFC);
    put(t, 4'b0000, 8'h22 << 2, "R4", TMRD);      // R4 second mode load
    for (int k = 0; k < 10; k++) begin
      put(t, 4'b0011, k, "R6", TRAS);
      put(t, 4'b0010, 1 << 10, "R6", TRP);
    end
    doneAt = t;                                    // R7
    ival = slow ? 2 * PRESC * PERIOD : PRESC * PERIOD;
    for (int n = 1; n <= bursts; n++) begin
      int b;
      b = doneAt + n * ival + 1;
      for (int j = 0; j < 4; j++) put(b, 4'b0001, 0, slow ? "R9" : "R8", TRFC);
    end
  endtask

  task automatic run_case(input bit slow, input int bursts);
    int last;
    int ec, ea;
    string rq;
    rstN = 1'b0;
    rateSlow = slow;
    build(slow, bursts);
    repeat (3) @(negedge clk);
    check("R1", "reset cmd", {sdCsN, sdRasN, sdCasN, sdWeN}, 4'b1111);
    check("R1", "reset addr", int'(sdAddr), 0);
    check("R1", "reset done", int'(initDone), 0);
    rstN = 1'b1;
    last = doneAt + bursts * (slow ? 2 : 1) * PRESC * PERIOD + 60;
    for (int c = 1; c <= last; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (expCmd.exists(c)) begin
        ec = expCmd[c]; ea = expAddr[c]; rq = expReq[c];
      end else begin
        ec = 4'b0111; ea = 0; rq = (c <= PWRUP) ? "R2" : "R5";
      end
      check(rq, "cmd", {sdCsN, sdRasN, sdCasN, sdWeN}, ec);
      check(rq, "addr", int'(sdAddr), ea);
      check("R7", "initDone", int'(initDone), (c >= doneAt) ? 1 : 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run_case(1'b0, 3);   // R8 fast rate
    run_case(1'b1, 2);   // R9 slow rate
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule